// File: doc/BRIEF.md
# ECC Read-Path Error Monitor

This block sits between a FIFO storage array and whatever reads from it. Every word leaving the memory is an extended Hamming codeword. Each beat the block decodes the word, repairs a single flipped bit on the spot, and marks a beat that carries two flipped bits as unrepairable. The decoded payload appears one clock after the read strobe.

Two 16-bit tallies run beside the data path. One counts repaired beats and the other counts unrepairable beats. Both stop at their maximum value rather than wrapping. They are presented together as one 32-bit count word, and a single clear input empties both. Each error class also has a sticky interrupt flag, which is cleared by its own write-one-to-clear bit.

An enable input switches checking on. Held low (its intended default), the block passes payload bits through untouched and never counts or flags.

Top module: `ecc_fifo_monitor`

## Requirements
- R1: With checking enabled, a clean codeword on a valid beat gives `outValid` high one cycle later, with `outData` equal to the payload and `outUncorr` low. Codeword layout: bit 0 holds even parity over the whole word; bits at power-of-two indices 1, 2, 4, ... hold Hamming check bits, each covering the indices that have that bit set; the payload fills the remaining indices in ascending order, payload bit 0 first.
- R2: A valid beat with exactly one flipped bit at any index (payload, check bit or bit 0) gives the original payload on `outData`, keeps `outUncorr` low, and adds one to `errCount[15:0]`.
- R3: Every repaired beat sets `irqSingle`. It stays set until a cycle with `intClear[0]` high and no new repaired beat; if both happen in the same cycle, the set wins.
- R4: A valid beat with two flipped bits (non-zero syndrome with even overall parity) passes the payload bits through unrepaired, raises `outUncorr` alongside that output beat, adds one to `errCount[31:16]`, and sets sticky `irqDouble`, which `intClear[1]` clears.
- R5: A beat whose overall parity is odd but whose syndrome points past the last codeword index is treated as unrepairable, exactly as in R4.
- R6: Each 16-bit half of `errCount` stops at 0xFFFF and holds there on further errors of its class.
- R7: `cntClear` zeroes both halves of `errCount` on the next edge and wins over an increment in the same cycle; it does not touch the interrupt flags.
- R8: With `eccEn` low, `outData` is the unrepaired payload bits, `outUncorr` stays low, and `errCount`, `irqSingle` and `irqDouble` do not change.
- R9: In a cycle with `rdValid` low, `outValid` is low on the next cycle and no count or flag changes, whatever is on `rdCode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eccEn | input | 1 | Checking enable |
| rdValid | input | 1 | A codeword from memory is present this cycle |
| rdCode | input | CODE_W (39) | Codeword read from storage |
| cntClear | input | 1 | Zero both error tallies |
| intClear | input | 2 | Write-one-to-clear: bit 0 for irqSingle, bit 1 for irqDouble |
| outValid | output | 1 | Decoded beat present |
| outData | output | DATA_W (32) | Repaired (or raw) payload |
| outUncorr | output | 1 | This beat could not be repaired |
| errCount | output | 2*CNT_W (32) | Repaired tally in the low half, unrepairable tally in the high half |
| irqSingle | output | 1 | Sticky repaired-error flag |
| irqDouble | output | 1 | Sticky unrepairable-error flag |

## Verification
The assertions assume that reset is applied first and that `eccEn`, `cntClear` and `intClear` are ordinary synchronous levels. They also rely on `outUncorr` appearing only with a decoded beat, and on a tally moving by at most one per cycle unless it is cleared. The bench drives every input on the falling edge and holds each one for a whole cycle. It builds codewords with its own encoder and flips chosen bits, so each beat carries a known number of errors: zero, one, two, or three placed so that the syndrome lands outside the word.

// File: rtl/ecc_mon_pkg.sv
package ecc_mon_pkg;

  // number of Hamming check bits needed for a payload width
  function automatic int chkBitsFor(int dataW);
    for (int p = 1; p < 16; p++) begin
      if ((1 << p) >= dataW + p + 1) return p;
    end
    return 16;
  endfunction

  // codeword index of payload bit j (skips 0 and power-of-two indices)
  function automatic int payloadPos(int j);
    int seen;
    seen = 0;
    for (int i = 1; i < 4096; i++) begin
      if ((i & (i - 1)) != 0) begin
        if (seen == j) return i;
        seen++;
      end
    end
    return 0;
  endfunction

  typedef struct packed {
    logic fixOne;   // repair the indicated bit and count a single error
    logic flagTwo;  // mark beat unrepairable and count a double error
  } eccStrobe_t;

endpackage

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   count <= '0;
    else if (clear)              count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/ecc_mon_ctrl.sv
module ecc_mon_ctrl
  import ecc_mon_pkg::*;
#(
  parameter int CHK_W  = 6,
  parameter int CODE_W = 39
) (
  input  logic             rdValid,
  input  logic             eccEn,
  input  logic [CHK_W-1:0] syndrome,
  input  logic             parOdd,
  output eccStrobe_t       strobe
);
  logic act;
  logic inRange;

  always_comb begin
    act     = rdValid && eccEn;
    inRange = int'(syndrome) < CODE_W;
    strobe.fixOne  = act && parOdd && inRange;
    strobe.flagTwo = act && ((!parOdd && syndrome != '0) || (parOdd && !inRange));
  end
endmodule

// File: rtl/ecc_mon_datapath.sv
module ecc_mon_datapath
  import ecc_mon_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHK_W  = 6,
  parameter int CODE_W = 39,
  parameter int CNT_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdValid,
  input  logic [CODE_W-1:0]  rdCode,
  input  eccStrobe_t         strobe,
  input  logic               cntClear,
  input  logic [1:0]         intClear,
  output logic [CHK_W-1:0]   syndrome,
  output logic               parOdd,
  output logic               outValid,
  output logic [DATA_W-1:0]  outData,
  output logic               outUncorr,
  output logic [2*CNT_W-1:0] errCount,
  output logic               irqSingle,
  output logic               irqDouble
);
  logic [CODE_W-1:0] flipMask;
  logic [CODE_W-1:0] fixedCode;
  logic [DATA_W-1:0] payload;
  logic [1:0]        incVec;
  logic [1:0]        irqVec;

  always_comb begin
    syndrome = '0;
    for (int i = 1; i < CODE_W; i++) begin
      if (rdCode[i]) syndrome = syndrome ^ CHK_W'(i);
    end
    parOdd    = ^rdCode;
    flipMask  = strobe.fixOne ? (CODE_W'(1) << syndrome) : '0;
    fixedCode = rdCode ^ flipMask;
  end

  for (genvar j = 0; j < DATA_W; j++) begin : g_extract
    assign payload[j] = fixedCode[payloadPos(j)];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      outUncorr <= 1'b0;
    end else begin
      outValid  <= rdValid;
      outUncorr <= strobe.flagTwo;
      if (rdValid) outData <= payload;
    end
  end

  assign incVec = {strobe.flagTwo, strobe.fixOne};

  for (genvar c = 0; c < 2; c++) begin : g_class
    ecc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .clear (cntClear),
      .inc   (incVec[c]),
      .count (errCount[c*CNT_W +: CNT_W])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) irqVec[c] <= 1'b0;
      else       irqVec[c] <= (irqVec[c] && !intClear[c]) || incVec[c];
    end
  end

  assign irqSingle = irqVec[0];
  assign irqDouble = irqVec[1];
endmodule

// File: rtl/ecc_fifo_monitor.sv
module ecc_fifo_monitor
  import ecc_mon_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  localparam int CHK_W  = chkBitsFor(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               eccEn,
  input  logic               rdValid,
  input  logic [CODE_W-1:0]  rdCode,
  input  logic               cntClear,
  input  logic [1:0]         intClear,
  output logic               outValid,
  output logic [DATA_W-1:0]  outData,
  output logic               outUncorr,
  output logic [2*CNT_W-1:0] errCount,
  output logic               irqSingle,
  output logic               irqDouble
);
  eccStrobe_t       strobe;
  logic [CHK_W-1:0] syndrome;
  logic             parOdd;

  ecc_mon_ctrl #(.CHK_W(CHK_W), .CODE_W(CODE_W)) u_ctrl (
    .rdValid  (rdValid),
    .eccEn    (eccEn),
    .syndrome (syndrome),
    .parOdd   (parOdd),
    .strobe   (strobe)
  );

  ecc_mon_datapath #(
    .DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rdValid   (rdValid),
    .rdCode    (rdCode),
    .strobe    (strobe),
    .cntClear  (cntClear),
    .intClear  (intClear),
    .syndrome  (syndrome),
    .parOdd    (parOdd),
    .outValid  (outValid),
    .outData   (outData),
    .outUncorr (outUncorr),
    .errCount  (errCount),
    .irqSingle (irqSingle),
    .irqDouble (irqDouble)
  );
endmodule

// File: rtl/ecc_fifo_monitor_sva.sv
module ecc_fifo_monitor_sva #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               eccEn,
  input logic               rdValid,
  input logic               cntClear,
  input logic [1:0]         intClear,
  input logic               outValid,
  input logic               outUncorr,
  input logic [2*CNT_W-1:0] errCount,
  input logic               irqSingle,
  input logic               irqDouble
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic [CNT_W-1:0] loCnt;
  logic [CNT_W-1:0] hiCnt;
  assign loCnt = errCount[CNT_W-1:0];
  assign hiCnt = errCount[2*CNT_W-1:CNT_W];

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !cntClear |=> (loCnt == $past(loCnt) || loCnt == $past(loCnt) + 1'b1)); // R2
  AST_SINGLE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqSingle && !intClear[0]) |=> irqSingle); // R3
  AST_DOUBLE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqDouble && !intClear[1]) |=> irqDouble); // R4
  AST_UNCORR_WITH_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    outUncorr |-> outValid); // R4
  AST_LO_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (loCnt == TOP && !cntClear) |=> loCnt == TOP); // R6
  AST_HI_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (hiCnt == TOP && !cntClear) |=> hiCnt == TOP); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cntClear |=> errCount == '0); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!eccEn && !cntClear) |=> $stable(errCount)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!rdValid && !cntClear) |=> ($stable(errCount) && !outValid)); // R9
  AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (!rdValid && !irqSingle) |=> !irqSingle); // R9
endmodule

bind ecc_fifo_monitor ecc_fifo_monitor_sva #(.CNT_W(CNT_W)) u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .eccEn     (eccEn),
  .rdValid   (rdValid),
  .cntClear  (cntClear),
  .intClear  (intClear),
  .outValid  (outValid),
  .outUncorr (outUncorr),
  .errCount  (errCount),
  .irqSingle (irqSingle),
  .irqDouble (irqDouble)
);

// File: tb/ecc_fifo_monitor_test.sv
`timescale 1ns/1ps
module ecc_fifo_monitor_test;
  localparam int DW = 32;
  localparam int CW = 39;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          eccEn = 1'b0;
  logic          rdValid = 1'b0;
  logic [CW-1:0] rdCode = '0;
  logic          cntClear = 1'b0;
  logic [1:0]    intClear = 2'b00;
  logic          outValid;
  logic [DW-1:0] outData;
  logic          outUncorr;
  logic [31:0]   errCount;
  logic          irqSingle;
  logic          irqDouble;

  int nChk = 0;
  int nFail = 0;
  logic [15:0] expLo = 0;
  logic [15:0] expHi = 0;

  always #2 clk = ~clk;

  ecc_fifo_monitor uut (
    .clk(clk), .rstN(rstN), .eccEn(eccEn), .rdValid(rdValid), .rdCode(rdCode),
    .cntClear(cntClear), .intClear(intClear), .outValid(outValid),
    .outData(outData), .outUncorr(outUncorr), .errCount(errCount),
    .irqSingle(irqSingle), .irqDouble(irqDouble)
  );

  function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int i = 1; i < CW; i++) begin
      if ((i & (i - 1)) != 0) begin
        c[i] = d[k];
        k++;
      end
    end
    for (int p = 0; p < 6; p++) begin
      logic par;
      par = 1'b0;
      for (int i = 1; i < CW; i++) if ((i & (1 << p)) != 0 && i != (1 << p)) par ^= c[i];
      c[1 << p] = par;
    end
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic logic [DW-1:0] rawBits(input logic [CW-1:0] c);
    logic [DW-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int i = 1; i < CW; i++) begin
      if ((i & (i - 1)) != 0) begin
        d[k] = c[i];
        k++;
      end
    end
    return d;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one beat; on return the clock edge has passed and outputs are settled
  task automatic beat(input logic [CW-1:0] code, input logic en, input logic valid,
                      input logic clr, input logic [1:0] iclr);
    eccEn = en; rdValid = valid; rdCode = code; cntClear = clr; intClear = iclr;
    @(negedge clk);
    rdValid = 1'b0; cntClear = 1'b0; intClear = 2'b00;
  endtask

  task automatic t_reset;
    chk("R1 reset outValid", outValid, 0);
    chk("R7 reset count", errCount, 0);
    chk("R3 reset irq", {irqDouble, irqSingle}, 0);
  endtask

  task automatic t_clean;
    logic [DW-1:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5C3_0F96, 32'h8000_0001};
    foreach (pats[n]) begin
      beat(encode(pats[n]), 1, 1, 0, 0);
      chk("R1 clean valid", outValid, 1);
      chk("R1 clean data", outData, pats[n]);
      chk("R1 clean uncorr", outUncorr, 0);
      chk("R1 clean count", errCount, {expHi, expLo});
    end
  endtask

  task automatic t_single;
    int pos [5] = '{0, 4, 3, 21, 38};
    logic [DW-1:0] d = 32'h1357_9BDF;
    foreach (pos[n]) begin
      logic [CW-1:0] c;
      c = encode(d);
      c[pos[n]] = ~c[pos[n]];
      beat(c, 1, 1, 0, 0);
      expLo++;
      chk("R2 single data", outData, d);
      chk("R2 single uncorr", outUncorr, 0);
      chk("R2 single count", errCount, {expHi, expLo});
      chk("R3 single irq", irqSingle, 1);
    end
    beat('0, 1, 0, 0, 2'b00);
    chk("R3 sticky", irqSingle, 1);
    beat('0, 1, 0, 0, 2'b01);
    chk("R3 cleared", irqSingle, 0);
    begin
      logic [CW-1:0] c;
      c = encode(d);
      c[9] = ~c[9];
      beat(c, 1, 1, 0, 2'b01);
      expLo++;
      chk("R3 set wins over clear", irqSingle, 1);
    end
  endtask

  task automatic t_double;
    logic [DW-1:0] d = 32'hDEAD_0420;
    logic [CW-1:0] c;
    c = encode(d);
    c[5] = ~c[5]; c[30] = ~c[30];
    beat(c, 1, 1, 0, 0);
    expHi++;
    chk("R4 double raw data", outData, rawBits(c));
    chk("R4 double uncorr", outUncorr, 1);
    chk("R4 double count", errCount, {expHi, expLo});
    chk("R4 double irq", irqDouble, 1);
    beat('0, 1, 0, 0, 2'b00);
    chk("R4 uncorr only with beat", outUncorr, 0);
    chk("R4 sticky", irqDouble, 1);
    beat('0, 1, 0, 0, 2'b10);
    chk("R4 cleared", irqDouble, 0);
    // three flips, odd parity, syndrome 32^7=39 beyond last index 38
    c = encode(d);
    c[32] = ~c[32]; c[7] = ~c[7]; c[0] = ~c[0];
    beat(c, 1, 1, 0, 0);
    expHi++;
    chk("R5 out-of-range uncorr", outUncorr, 1);
    chk("R5 out-of-range data", outData, rawBits(c));
    chk("R5 out-of-range count", errCount, {expHi, expLo});
  endtask

  task automatic t_disabled_idle;
    logic [DW-1:0] d = 32'h0F0F_7777;
    logic [CW-1:0] c;
    beat('0, 1, 0, 0, 2'b11);
    c = encode(d);
    c[12] = ~c[12];
    beat(c, 0, 1, 0, 0);
    chk("R8 disabled raw data", outData, rawBits(c));
    chk("R8 disabled uncorr", outUncorr, 0);
    chk("R8 disabled count", errCount, {expHi, expLo});
    chk("R8 disabled irq", {irqDouble, irqSingle}, 0);
    c[20] = ~c[20];
    beat(c, 1, 0, 0, 0);
    chk("R9 idle valid", outValid, 0);
    chk("R9 idle count", errCount, {expHi, expLo});
    chk("R9 idle irq", {irqDouble, irqSingle}, 0);
  endtask

  task automatic t_clear;
    logic [CW-1:0] c;
    c = encode(32'h2468_ACE0);
    c[17] = ~c[17];
    beat(c, 1, 1, 1, 0);
    expLo = 0; expHi = 0;
    chk("R7 clear wins", errCount, 0);
    chk("R7 clear keeps irq", irqSingle, 1);
  endtask

  task automatic t_saturate;
    logic [CW-1:0] c;
    c = encode(32'h5555_AAAA);
    c[2] = ~c[2];
    eccEn = 1; rdValid = 1; rdCode = c;
    repeat (65536) @(negedge clk);
    rdValid = 0;
    chk("R6 saturated low half", errCount[15:0], 16'hFFFF);
    beat(c, 1, 1, 0, 0);
    chk("R6 holds at max", errCount[15:0], 16'hFFFF);
    chk("R6 other half untouched", errCount[31:16], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_single();
    t_double();
    t_disabled_idle();
    t_clear();
    t_saturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule